// File: doc/BRIEF.md
# Cascaded fixed-point Butterworth IIR filter

This block filters a stream of signed integer samples with a Butterworth response that is either lowpass or highpass, of order 1, 2 or 4. A sample is taken on every clock edge where `in_valid` is high. The filtered sample appears a fixed number of cycles later with `out_valid`. Coefficients are elaboration-time parameters, computed offline from the ratio of cutoff frequency to sample rate. That ratio must stay below one half. The block never sees an absolute frequency.

Orders 2 and 4 use one or two second-order direct-form-I sections. Order 1 uses a single first-order section. The response type fixes the numerator shape, so each section needs only a gain and its feedback coefficients. The input can be a 16-bit word, a 24-bit value carried in the low bits of a 32-bit word, or a full 32-bit word. An optional synchronous clear input flushes all filter state while the filter runs.

Top module: `iir_bw_filter`

## Requirements
- R1: Each sample accepted with `in_valid` produces exactly one `out_valid` pulse, one cycle per section later (1 cycle for orders 1 and 2, 2 cycles for order 4). While no result is emitted, `out_data` holds its last value.
- R2: Every section computes y = g·(x + k1·x[n-1] + k2·x[n-2]) − a1·y[n-1] − a2·y[n-2]. The numerator weights are (1, 2, 1) for second-order lowpass, (1, −2, 1) for second-order highpass, (1, 1) for first-order lowpass and (1, −1) for first-order highpass. Coefficients are signed Q2.(COEF_W−2). The sum is exact and is rounded by adding half an LSB and then shifting right arithmetically.
- R3: Each section result saturates to the signed range of the significant input width: 16, 24 or 32 bits.
- R4: For a constant input, a lowpass instance settles to within 8 LSB of the input.
- R5: For a constant input, a highpass instance settles to within 8 LSB of zero.
- R6: In 24-bit mode (IN_MODE = 1), bits 31:24 of `in_data` are ignored and the sample is bits 23:0 taken as signed. `out_data` is the 24-bit result sign-extended to 32 bits.
- R7: With HAS_CLR = 1, a high `clr` at an edge zeroes every state register and `out_data` and drops `out_valid`. A sample offered on that same edge is discarded. The next output is the response of a zero-state filter.
- R8: With HAS_CLR = 0, `clr` has no effect on any output.
- R9: An order-4 instance accepts a new sample on every cycle and streams results back to back.
- R10: While `rst` is high at a clock edge, `out_valid` and `out_data` go to zero and all state clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Run-time state clear, honoured only when HAS_CLR = 1 |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 or 32 | Input sample: 16 bits in IN_MODE 0, otherwise 32 |
| out_valid | output | 1 | Result strobe |
| out_data | output | 16 or 32 | Filtered sample, same width as `in_data` |

## Verification
The hardest situation to reach from the ports is saturation inside the recursion. A clipped value is fed back as state, so every later sample depends on it. The bench drives full-scale steps into the second-order lowpass until its overshoot clips at both rails. It keeps comparing bit-exactly against an integer reference afterwards. The second hard case is a clear that arrives together with a sample after the state is nonzero. The bench then checks that the first sample after the clear yields only the zero-state product.

// File: rtl/bwf_pkg.sv
package bwf_pkg;

   typedef enum logic [0:0] {
      RESP_LOW  = 1'b0,
      RESP_HIGH = 1'b1
   } resp_e;

   // Input mode 0: 16-bit word, 1: 24 significant bits in a 32-bit word, 2: 32 bits
   function automatic int port_w(input int mode);
      return (mode == 0) ? 16 : 32;
   endfunction

   function automatic int sig_w(input int mode);
      return (mode == 0) ? 16 : ((mode == 1) ? 24 : 32);
   endfunction

   function automatic bit coef_fits(input int v, input int w);
      return (v <= (2 ** (w - 1)) - 1) && (v >= -(2 ** (w - 1)));
   endfunction

endpackage

// File: rtl/bwf_in_cond.sv
module bwf_in_cond #(
   parameter int PORT_W = 16,
   parameter int SIG_W  = 16
) (
   input  logic [PORT_W-1:0]       raw,
   output logic signed [SIG_W-1:0] smp
);

   assign smp = raw[SIG_W-1:0];

   generate
      if (SIG_W < PORT_W) begin : g_drop_hi
         logic unused_hi;
         assign unused_hi = ^raw[PORT_W-1:SIG_W];
      end
   endgenerate

endmodule

// File: rtl/bwf_rndsat.sv
module bwf_rndsat #(
   parameter int ACC_W = 38,
   parameter int FRAC  = 16,
   parameter int SIG_W = 16
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic signed [SIG_W-1:0] y
);

   localparam logic signed [ACC_W-1:0] HALF =
      {{(ACC_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
   localparam logic signed [ACC_W-1:0] HI =
      {{(ACC_W-SIG_W+1){1'b0}}, {(SIG_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] LO = ~HI;

   logic signed [ACC_W-1:0] biased;
   logic signed [ACC_W-1:0] shifted;

   assign biased  = acc + HALF;
   assign shifted = biased >>> FRAC;

   always_comb begin
      if (shifted > HI)
         y = HI[SIG_W-1:0];
      else if (shifted < LO)
         y = LO[SIG_W-1:0];
      else
         y = shifted[SIG_W-1:0];
   end

endmodule

// File: rtl/bwf_section.sv
module bwf_section #(
   parameter int SIG_W  = 16,
   parameter int COEF_W = 18,
   parameter bit SECOND = 1'b1,
   parameter bit HIGH   = 1'b0,
   parameter int GAIN   = 0,
   parameter int A1     = 0,
   parameter int A2     = 0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clr,
   input  logic                    vin,
   input  logic signed [SIG_W-1:0] x,
   output logic                    vout,
   output logic signed [SIG_W-1:0] y
);

   localparam int FRAC  = COEF_W - 2;
   localparam int ACC_W = SIG_W + COEF_W + 4;

   localparam logic signed [COEF_W-1:0] CG  = COEF_W'(GAIN);
   localparam logic signed [COEF_W-1:0] CA1 = COEF_W'(A1);
   localparam logic signed [COEF_W-1:0] CA2 = COEF_W'(A2);

   logic signed [ACC_W-1:0] g_e, a1_e, a2_e;
   logic signed [SIG_W-1:0] x1_q;
   logic signed [SIG_W-1:0] y_q;
   logic signed [SIG_W-1:0] y_new;
   logic signed [ACC_W-1:0] t0, t1, fb1;
   logic signed [ACC_W-1:0] fwd, fbk, acc;

   assign g_e  = ACC_W'(CG);
   assign a1_e = ACC_W'(CA1);
   assign a2_e = ACC_W'(CA2);

   assign t0  = ACC_W'(x) * g_e;
   assign t1  = ACC_W'(x1_q) * g_e;
   assign fb1 = ACC_W'(y_q) * a1_e;

   generate
      if (SECOND) begin : g_biquad
         logic signed [SIG_W-1:0] x2_q, y2_q;
         logic signed [ACC_W-1:0] t2, fb2;

         assign t2  = ACC_W'(x2_q) * g_e;
         assign fb2 = ACC_W'(y2_q) * a2_e;

         if (HIGH) begin : g_hp
            assign fwd = t0 - (t1 <<< 1) + t2;
         end else begin : g_lp
            assign fwd = t0 + (t1 <<< 1) + t2;
         end
         assign fbk = fb1 + fb2;

         always_ff @(posedge clk) begin
            if (rst || clr) begin
               x2_q <= '0;
               y2_q <= '0;
            end else if (vin) begin
               x2_q <= x1_q;
               y2_q <= y_q;
            end
         end
      end else begin : g_first
         logic signed [ACC_W-1:0] unused_a2;
         assign unused_a2 = a2_e;
         if (HIGH) begin : g_hp
            assign fwd = t0 - t1;
         end else begin : g_lp
            assign fwd = t0 + t1;
         end
         assign fbk = fb1;
      end
   endgenerate

   assign acc = fwd - fbk;

   bwf_rndsat #(
      .ACC_W (ACC_W),
      .FRAC  (FRAC),
      .SIG_W (SIG_W)
   ) u_rs (
      .acc (acc),
      .y   (y_new)
   );

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         x1_q <= '0;
         y_q  <= '0;
         vout <= 1'b0;
      end else begin
         vout <= vin;
         if (vin) begin
            x1_q <= x;
            y_q  <= y_new;
         end
      end
   end

   assign y = y_q;

endmodule

// File: rtl/iir_bw_filter.sv
module iir_bw_filter #(
   parameter bwf_pkg::resp_e RESP = bwf_pkg::RESP_LOW,
   parameter int ORDER    = 2,
   parameter int IN_MODE  = 0,
   parameter bit HAS_CLR  = 1'b1,
   parameter int COEF_W   = 18,
   parameter int S0_GAIN  = 4421,
   parameter int S0_A1    = -74906,
   parameter int S0_A2    = 27053,
   parameter int S1_GAIN  = 5109,
   parameter int S1_A1    = -86567,
   parameter int S1_A2    = 41466,
   localparam int PORT_W  = bwf_pkg::port_w(IN_MODE)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              in_valid,
   input  logic [PORT_W-1:0] in_data,
   output logic              out_valid,
   output logic [PORT_W-1:0] out_data
);

   localparam int SIG_W  = bwf_pkg::sig_w(IN_MODE);
   localparam int NSEC   = (ORDER == 4) ? 2 : 1;
   localparam bit SECOND = (ORDER != 1);
   localparam bit HIGH   = (RESP == bwf_pkg::RESP_HIGH);

   generate
      if (!(ORDER == 1 || ORDER == 2 || ORDER == 4)) begin : g_bad_order
         $error("iir_bw_filter: ORDER must be 1, 2 or 4");
      end
      if (IN_MODE < 0 || IN_MODE > 2) begin : g_bad_mode
         $error("iir_bw_filter: IN_MODE must be 0, 1 or 2");
      end
      if (COEF_W < 4 || COEF_W > 30) begin : g_bad_cw
         $error("iir_bw_filter: COEF_W out of range");
      end
      if (!bwf_pkg::coef_fits(S0_GAIN, COEF_W) || !bwf_pkg::coef_fits(S0_A1, COEF_W) ||
          !bwf_pkg::coef_fits(S0_A2, COEF_W) || !bwf_pkg::coef_fits(S1_GAIN, COEF_W) ||
          !bwf_pkg::coef_fits(S1_A1, COEF_W) || !bwf_pkg::coef_fits(S1_A2, COEF_W)) begin : g_bad_coef
         $error("iir_bw_filter: coefficient does not fit COEF_W");
      end
   endgenerate

   logic clr_eff;

   generate
      if (HAS_CLR) begin : g_clr
         assign clr_eff = clr;
      end else begin : g_noclr
         logic unused_clr;
         assign unused_clr = clr;
         assign clr_eff    = 1'b0;
      end
   endgenerate

   logic                    v_c [NSEC+1];
   logic signed [SIG_W-1:0] d_c [NSEC+1];

   bwf_in_cond #(
      .PORT_W (PORT_W),
      .SIG_W  (SIG_W)
   ) u_in (
      .raw (in_data),
      .smp (d_c[0])
   );
   assign v_c[0] = in_valid;

   generate
      for (genvar i = 0; i < NSEC; i++) begin : g_sec
         bwf_section #(
            .SIG_W  (SIG_W),
            .COEF_W (COEF_W),
            .SECOND (SECOND),
            .HIGH   (HIGH),
            .GAIN   ((i == 0) ? S0_GAIN : S1_GAIN),
            .A1     ((i == 0) ? S0_A1 : S1_A1),
            .A2     ((i == 0) ? S0_A2 : S1_A2)
         ) u_sec (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr_eff),
            .vin  (v_c[i]),
            .x    (d_c[i]),
            .vout (v_c[i+1]),
            .y    (d_c[i+1])
         );
      end
   endgenerate

   assign out_valid = v_c[NSEC];
   assign out_data  = PORT_W'(d_c[NSEC]);

endmodule

// File: rtl/bwf_chk.sv
module bwf_chk #(
   parameter int PORT_W = 16,
   parameter int SIG_W  = 16,
   parameter int NSEC   = 1
) (
   input logic              clk,
   input logic              rst,
   input logic              clr_eff,
   input logic              in_valid,
   input logic              out_valid,
   input logic [PORT_W-1:0] out_data
);

   // R1: a result is only emitted for a sample taken NSEC cycles before
   p_latency_r1: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, NSEC));

   // R1: without a result and without a clear the output holds
   p_hold_r1: assert property (@(posedge clk) disable iff (rst)
      (!out_valid && !$past(clr_eff)) |-> $stable(out_data));

   // R7: a clear empties the output stage
   p_clear_r7: assert property (@(posedge clk) disable iff (rst)
      clr_eff |=> (!out_valid && out_data == '0));

   // R10: the cycle after reset shows an idle, zero output
   p_reset_r10: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0));

   generate
      if (SIG_W < PORT_W) begin : g_rng
         localparam logic signed [PORT_W-1:0] HI =
            {{(PORT_W-SIG_W+1){1'b0}}, {(SIG_W-1){1'b1}}};
         localparam logic signed [PORT_W-1:0] LO = ~HI;
         // R3, R6: the result stays inside the significant range, sign-extended
         p_range_r3: assert property (@(posedge clk) disable iff (rst)
            ($signed(out_data) <= HI) && ($signed(out_data) >= LO));
      end
   endgenerate

endmodule

bind iir_bw_filter bwf_chk #(
   .PORT_W (PORT_W),
   .SIG_W  (SIG_W),
   .NSEC   (NSEC)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .clr_eff   (clr_eff),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/sim_iir_bw_filter.sv
`timescale 1ns/1ps
module sim_iir_bw_filter;

   localparam int G0 = 4421,  A10 = -74906, A20 = 27053;
   localparam int G1A = 38417, A11A = -68722, A21A = 19408;
   localparam int G1B = 48392, A11B = -86567, A21B = 41466;
   localparam int G2 = 16071, A12 = -33393;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic        v0 = 0, c0 = 0, v1 = 0, c1 = 0, v2 = 0, c2 = 0;
   logic [15:0] d0 = '0;
   logic [31:0] d1 = '0, d2 = '0;
   logic        ov0, ov1, ov2;
   logic [15:0] od0;
   logic [31:0] od1, od2;

   int       n_chk = 0;
   int       n_err = 0;
   longint   st [4][4];
   longint   lastv;
   bit [7:0] junk = 8'h5A;

   iir_bw_filter u0 (
      .clk(clk), .rst(rst), .clr(c0), .in_valid(v0), .in_data(d0),
      .out_valid(ov0), .out_data(od0));

   iir_bw_filter #(
      .RESP(bwf_pkg::RESP_HIGH), .ORDER(4), .IN_MODE(1), .HAS_CLR(1'b1),
      .S0_GAIN(G1A), .S0_A1(A11A), .S0_A2(A21A),
      .S1_GAIN(G1B), .S1_A1(A11B), .S1_A2(A21B)
   ) u1 (
      .clk(clk), .rst(rst), .clr(c1), .in_valid(v1), .in_data(d1),
      .out_valid(ov1), .out_data(od1));

   iir_bw_filter #(
      .RESP(bwf_pkg::RESP_LOW), .ORDER(1), .IN_MODE(2), .HAS_CLR(1'b0),
      .S0_GAIN(G2), .S0_A1(A12), .S0_A2(0)
   ) u2 (
      .clk(clk), .rst(rst), .clr(c2), .in_valid(v2), .in_data(d2),
      .out_valid(ov2), .out_data(od2));

   // Integer reference section; state slots: 0 x1, 1 x2, 2 y1, 3 y2
   function automatic longint sec_step(input int s, input longint x, input int sw,
                                       input longint g, input longint a1, input longint a2,
                                       input bit second, input bit hp);
      longint fwd, acc, r, mx;
      if (second)
         fwd = hp ? g*x - 2*g*st[s][0] + g*st[s][1] : g*x + 2*g*st[s][0] + g*st[s][1];
      else
         fwd = hp ? g*x - g*st[s][0] : g*x + g*st[s][0];
      acc = fwd - a1*st[s][2] - (second ? a2*st[s][3] : 64'sd0);
      r   = (acc + 64'sd32768) >>> 16;
      mx  = (64'sd1 <<< (sw - 1)) - 1;
      if (r > mx) r = mx;
      if (r < -mx - 1) r = -mx - 1;
      st[s][1] = st[s][0];
      st[s][0] = x;
      st[s][3] = st[s][2];
      st[s][2] = r;
      return r;
   endfunction

   function automatic longint model(input int inst, input longint x);
      longint t;
      if (inst == 0) return sec_step(0, x, 16, G0, A10, A20, 1'b1, 1'b0);
      if (inst == 1) begin
         t = sec_step(1, x, 24, G1A, A11A, A21A, 1'b1, 1'b1);
         return sec_step(2, t, 24, G1B, A11B, A21B, 1'b1, 1'b1);
      end
      return sec_step(3, x, 32, G2, A12, 0, 1'b0, 1'b0);
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_tol(input string req, input longint act, input longint exp, input longint tol);
      longint d;
      n_chk++;
      d = act - exp;
      if (d < 0) d = -d;
      if (d > tol) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d (+/-%0d)", req, act, exp, tol);
      end
   endtask

   function automatic longint outv(input int inst);
      if (inst == 0) return longint'($signed(od0));
      if (inst == 1) return longint'($signed(od1));
      return longint'($signed(od2));
   endfunction

   // one sample, then wait out the latency and compare with the reference
   task automatic send(input int inst, input longint x, input string req);
      longint exp;
      logic   ov;
      @(negedge clk);
      case (inst)
         0: begin v0 = 1'b1; d0 = 16'(x); end
         1: begin v1 = 1'b1; d1 = {junk, 24'(x)}; junk = junk + 8'd29; end
         default: begin v2 = 1'b1; d2 = 32'(x); end
      endcase
      @(negedge clk);
      v0 = 1'b0; v1 = 1'b0; v2 = 1'b0;
      if (inst == 1) @(negedge clk);
      exp   = model(inst, x);
      ov    = (inst == 0) ? ov0 : ((inst == 1) ? ov1 : ov2);
      lastv = outv(inst);
      chk(req, lastv, exp);
      chk({req, " out_valid"}, longint'(ov), 1);
   endtask

   task automatic t_reset;
      chk("R10 valid u0", longint'(ov0), 0);
      chk("R10 valid u1", longint'(ov1), 0);
      chk("R10 valid u2", longint'(ov2), 0);
      chk("R10 data u0", outv(0), 0);
      chk("R10 data u1", outv(1), 0);
   endtask

   task automatic t_mixed_u0;
      for (int i = 0; i < 20; i++)
         send(0, longint'((i * 3571) % 20000) - 10000, "R2 u0 mixed");
   endtask

   task automatic t_hold_u0;
      longint held;
      held = outv(0);
      repeat (5) @(negedge clk);
      chk("R1 idle valid", longint'(ov0), 0);
      chk("R1 idle hold", outv(0), held);
   endtask

   task automatic t_clear_u0;
      send(0, 15000, "R2 pre-clear");
      send(0, -7000, "R2 pre-clear");
      @(negedge clk);
      c0 = 1'b1; v0 = 1'b1; d0 = 16'd12345;
      @(negedge clk);
      c0 = 1'b0; v0 = 1'b0;
      chk("R7 clear valid", longint'(ov0), 0);
      chk("R7 clear data", outv(0), 0);
      for (int k = 0; k < 4; k++) st[0][k] = 0;
      send(0, 20000, "R7 first after clear");
      chk("R7 zero-state value", lastv, 1349);
   endtask

   task automatic t_sat_u0;
      longint mx, mn;
      mx = -100000; mn = 100000;
      for (int i = 0; i < 30; i++) begin
         send(0, 32767, "R3 u0 positive step");
         if (lastv > mx) mx = lastv;
      end
      chk("R3 clip high", mx, 32767);
      for (int i = 0; i < 30; i++) begin
         send(0, -32768, "R3 u0 negative step");
         if (lastv < mn) mn = lastv;
      end
      chk("R3 clip low", mn, -32768);
   endtask

   task automatic t_lp_settle;
      for (int i = 0; i < 60; i++) send(0, 10000, "R2 u0 dc");
      chk_tol("R4 u0 settles", lastv, 10000, 8);
      for (int i = 0; i < 60; i++) send(2, 10000, "R2 u2 dc");
      chk_tol("R4 u2 settles", lastv, 10000, 8);
   endtask

   task automatic t_u1_patterns;
      for (int i = 0; i < 16; i++)
         send(1, (i % 2 == 1) ? 64'sd4000000 : -64'sd4000000, "R6 u1 alternating");
      for (int i = 0; i < 16; i++)
         send(1, longint'(i) * 900000 - 7000000, "R6 u1 ramp");
      send(1, -8388608, "R6 u1 most negative");
   endtask

   task automatic t_burst_u1;
      longint xs [12];
      longint ex [12];
      for (int i = 0; i < 12; i++) begin
         xs[i] = longint'((i * 1234567) % 6000000) - 3000000;
         ex[i] = model(1, xs[i]);
      end
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         if (i >= 2) begin
            chk("R9 burst valid", longint'(ov1), 1);
            chk("R9 burst data", outv(1), ex[i-2]);
         end
         if (i < 12) begin
            v1 = 1'b1;
            d1 = {junk, 24'(xs[i])};
            junk = junk + 8'd13;
         end else begin
            v1 = 1'b0;
         end
      end
      @(negedge clk);
      chk("R1 burst ends", longint'(ov1), 0);
   endtask

   task automatic t_hp_settle;
      for (int i = 0; i < 80; i++) send(1, 3000000, "R2 u1 dc");
      chk_tol("R5 u1 settles", lastv, 0, 8);
   endtask

   task automatic t_u2_large;
      for (int i = 0; i < 12; i++) send(2, 2000000000, "R2 u2 large positive");
      for (int i = 0; i < 12; i++) send(2, -2100000000, "R2 u2 large negative");
   endtask

   task automatic t_noclr_u2;
      longint held;
      send(2, 777777, "R2 u2 before clr");
      held = outv(2);
      @(negedge clk);
      c2 = 1'b1;
      @(negedge clk);
      c2 = 1'b0;
      chk("R8 data kept", outv(2), held);
      @(negedge clk);
      c2 = 1'b1; v2 = 1'b1; d2 = 32'd555555;
      @(negedge clk);
      c2 = 1'b0; v2 = 1'b0;
      chk("R8 sample kept", outv(2), model(2, 555555));
      chk("R8 valid kept", longint'(ov2), 1);
      for (int i = 0; i < 4; i++) send(2, -333333, "R8 state kept");
   endtask

   initial begin
      for (int s = 0; s < 4; s++)
         for (int k = 0; k < 4; k++) st[s][k] = 0;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_mixed_u0();
      t_hold_u0();
      t_clear_u0();
      t_sat_u0();
      t_lp_settle();
      t_u1_patterns();
      t_burst_u1();
      t_hp_settle();
      t_u2_large();
      t_noclr_u2();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule